// File: doc/BRIEF.md
# Legacy Keyboard Controller Command Decoder

This block decodes the byte traffic a host sends to a legacy PC keyboard controller. Every host write is tagged as either a command-port byte or a data-port byte. Command bytes are decoded at once. Some commands put a one-byte response on a valid/ready output stream. Other commands arm a data-port state, so that the next data byte goes to a special target instead of the keyboard path.

The block keeps the address-line-20 gate flag (`a20_gate`). Four command forms change it:
- the dedicated enable command and the dedicated disable command;
- the pulse-output-bit command range;
- the write-output-port command followed by its data byte.

The read-output-port command returns a status byte built from the gate flag and two status inputs. The block also holds a 32-byte controller RAM, which can be written and read back by command. An unsupported command does nothing except raise a one-cycle error pulse.

A data byte that arrives while no data state is armed goes out on a keyboard-data strobe. A new command byte always cancels an armed data state before the new command is decoded.

Top module: `kbc_cmd_decoder`

## Requirements
- R1: After reset `a20_gate` is 0, `rsp_valid`, `kbd_valid` and `err_pulse` are 0, and RAM byte 0 holds 0x45 while the other RAM bytes hold 0x00.
- R2: Command 0xD0 loads one response byte on the clock edge that takes it. In that byte, bit 5 equals `host_in_pending`, bit 4 equals `out_char_waiting`, bit 1 equals `a20_gate`, bit 0 is 1, and all other bits are 0.
- R3: Command 0xD1 gives no response and arms the output-port state. The next data byte sets `a20_gate` to bit 1 of that byte, produces no `kbd_valid`, and returns the decoder to its normal state.
- R4: Command 0xDD clears `a20_gate` and command 0xDF sets it. On a cycle with no host write, `a20_gate` does not change.
- R5: Each command from 0xF0 to 0xFF sets `a20_gate` to bit 1 of the command byte.
- R6: Command 0xAA returns the response byte 0x55.
- R7: Command 0x60+n (n from 0 to 31) arms a RAM-write state, and the next data byte is stored at address n. Command 0x20+n returns RAM byte n as a response.
- R8: A data byte that arrives in the normal state produces `kbd_valid` for exactly one cycle, with `kbd_data` equal to that byte, on the edge that takes it. It leaves `a20_gate` unchanged.
- R9: A command byte written while a data state is armed cancels that state. The following data byte is then treated as keyboard data.
- R10: A command outside the supported set raises `err_pulse` for one cycle. It gives no response and does not change `a20_gate`.
- R11: A response stays on `rsp_data` with `rsp_valid` high until `rsp_ready` is seen high. It is then cleared, unless a new response is loaded on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A host byte is written this cycle |
| wr_is_cmd | input | 1 | 1 = command port, 0 = data port |
| wr_byte | input | 8 | Written byte |
| host_in_pending | input | 1 | Host input is still pending |
| out_char_waiting | input | 1 | An output character is waiting |
| rsp_ready | input | 1 | Consumer accepts the response byte |
| rsp_valid | output | 1 | Response byte is available |
| rsp_data | output | 8 | Response byte |
| kbd_valid | output | 1 | Keyboard-data strobe |
| kbd_data | output | 8 | Keyboard-data byte |
| a20_gate | output | 1 | Address-line-20 gate flag |
| err_pulse | output | 1 | Unsupported-command pulse |

## Verification
The case that is hardest to reach from the ports is an armed data state that is interrupted. A 0xD1 or 0x60+n command has to be followed by a different command byte before any data byte arrives. Only then does a data byte show whether the decoder fell back to its normal state. The stimulus therefore sends 0xD1 first, then a gate command that moves the flag to a known value, then a data byte with bit 1 set to the opposite value. The bench then checks that this byte appears on the keyboard strobe and that the gate flag keeps the value the interrupting command gave it. The same sequence is repeated for the RAM-write state: the armed address is read back afterwards and must be unchanged.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

  localparam logic [7:0] OP_RD_OUTPORT = 8'hD0;
  localparam logic [7:0] OP_WR_OUTPORT = 8'hD1;
  localparam logic [7:0] OP_GATE_OFF   = 8'hDD;
  localparam logic [7:0] OP_GATE_ON    = 8'hDF;
  localparam logic [7:0] OP_SELFTEST   = 8'hAA;
  localparam logic [7:0] SELFTEST_PASS = 8'h55;
  localparam logic [2:0] RAMRD_TOP     = 3'b001;  // 0x20..0x3F
  localparam logic [2:0] RAMWR_TOP     = 3'b011;  // 0x60..0x7F
  localparam logic [3:0] PULSE_TOP     = 4'hF;    // 0xF0..0xFF

  typedef enum logic [3:0] {
    CK_BAD,
    CK_RD_OUTPORT,
    CK_WR_OUTPORT,
    CK_GATE_OFF,
    CK_GATE_ON,
    CK_PULSE,
    CK_SELFTEST,
    CK_RAM_RD,
    CK_RAM_WR
  } cmd_kind_e;

  typedef enum logic [1:0] {
    PS_NORMAL,
    PS_OUTPORT,
    PS_RAMWR
  } port_state_e;

  function automatic cmd_kind_e classify(input logic [7:0] c);
    cmd_kind_e k;
    k = CK_BAD;
    if (c == OP_RD_OUTPORT)         k = CK_RD_OUTPORT;
    else if (c == OP_WR_OUTPORT)    k = CK_WR_OUTPORT;
    else if (c == OP_GATE_OFF)      k = CK_GATE_OFF;
    else if (c == OP_GATE_ON)       k = CK_GATE_ON;
    else if (c == OP_SELFTEST)      k = CK_SELFTEST;
    else if (c[7:4] == PULSE_TOP)   k = CK_PULSE;
    else if (c[7:5] == RAMRD_TOP)   k = CK_RAM_RD;
    else if (c[7:5] == RAMWR_TOP)   k = CK_RAM_WR;
    return k;
  endfunction

  function automatic logic [7:0] outport_status(input logic pend,
                                                input logic chr,
                                                input logic gate);
    return {2'b00, pend, chr, 2'b00, gate, 1'b1};
  endfunction

  function automatic logic gate_from_byte(input logic [7:0] b);
    return b[1];
  endfunction

endpackage

// File: rtl/kbc_cmd_classify.sv
module kbc_cmd_classify
  import kbc_pkg::*;
#(
  parameter int RAM_DEPTH = 32,
  localparam int AW = $clog2(RAM_DEPTH)
) (
  input  logic [7:0]   cmd_byte,
  output cmd_kind_e    cmd_kind,
  output logic [AW-1:0] cmd_addr
);
  always_comb begin
    cmd_kind = classify(cmd_byte);
    cmd_addr = cmd_byte[AW-1:0];
  end
endmodule

// File: rtl/kbc_ctl_ram.sv
module kbc_ctl_ram #(
  parameter int         DEPTH    = 32,
  parameter int         DW       = 8,
  parameter logic [7:0] DEFAULT0 = 8'h45,
  localparam int        AW       = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    localparam logic [DW-1:0] INIT = (i == 0) ? DW'(DEFAULT0) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)                        mem[i] <= INIT;
      else if (we && waddr == AW'(i))    mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  AST_RAM_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata)) else $error("ram write lost"); // R7
endmodule

// File: rtl/kbc_rsp_hold.sv
module kbc_rsp_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_byte,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_byte;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !load) |=> (rsp_valid && rsp_data == $past(rsp_data)))
    else $error("response dropped"); // R11
endmodule

// File: rtl/kbc_cmd_decoder.sv
module kbc_cmd_decoder
  import kbc_pkg::*;
#(
  parameter int         RAM_DEPTH = 32,
  parameter logic [7:0] RAM0_INIT = 8'h45,
  localparam int        AW        = $clog2(RAM_DEPTH)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic       wr_is_cmd,
  input  logic [7:0] wr_byte,
  input  logic       host_in_pending,
  input  logic       out_char_waiting,
  input  logic       rsp_ready,
  output logic       rsp_valid,
  output logic [7:0] rsp_data,
  output logic       kbd_valid,
  output logic [7:0] kbd_data,
  output logic       a20_gate,
  output logic       err_pulse
);
  // named events
  logic          ev_cmd, ev_data;
  cmd_kind_e     kind;
  logic [AW-1:0] cmd_addr;
  port_state_e   pstate_q, pstate_d;
  logic [AW-1:0] ram_addr_q;
  logic          gate_d;
  logic          ram_we;
  logic [7:0]    ram_rdata;
  logic          rsp_load;
  logic [7:0]    rsp_byte;
  logic          kbd_hit, bad_hit;

  assign ev_cmd  = wr_valid &&  wr_is_cmd;
  assign ev_data = wr_valid && !wr_is_cmd;

  kbc_cmd_classify #(.RAM_DEPTH(RAM_DEPTH)) u_cls (
    .cmd_byte (wr_byte),
    .cmd_kind (kind),
    .cmd_addr (cmd_addr)
  );

  // data-port state: a command always restarts from normal
  always_comb begin
    pstate_d = pstate_q;
    if (ev_cmd) begin
      unique case (kind)
        CK_WR_OUTPORT: pstate_d = PS_OUTPORT;
        CK_RAM_WR:     pstate_d = PS_RAMWR;
        default:       pstate_d = PS_NORMAL;
      endcase
    end else if (ev_data) begin
      pstate_d = PS_NORMAL;
    end
  end

  always_comb begin
    gate_d = a20_gate;
    if (ev_cmd) begin
      case (kind)
        CK_GATE_OFF: gate_d = 1'b0;
        CK_GATE_ON:  gate_d = 1'b1;
        CK_PULSE:    gate_d = gate_from_byte(wr_byte);
        default:     gate_d = a20_gate;
      endcase
    end else if (ev_data && pstate_q == PS_OUTPORT) begin
      gate_d = gate_from_byte(wr_byte);
    end
  end

  assign ram_we  = ev_data && pstate_q == PS_RAMWR;
  assign kbd_hit = ev_data && pstate_q == PS_NORMAL;
  assign bad_hit = ev_cmd && kind == CK_BAD;

  always_comb begin
    rsp_load = 1'b0;
    rsp_byte = '0;
    if (ev_cmd) begin
      case (kind)
        CK_RD_OUTPORT: begin
          rsp_load = 1'b1;
          rsp_byte = outport_status(host_in_pending, out_char_waiting, a20_gate);
        end
        CK_SELFTEST: begin
          rsp_load = 1'b1;
          rsp_byte = SELFTEST_PASS;
        end
        CK_RAM_RD: begin
          rsp_load = 1'b1;
          rsp_byte = ram_rdata;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pstate_q   <= PS_NORMAL;
      ram_addr_q <= '0;
      a20_gate   <= 1'b0;
      kbd_valid  <= 1'b0;
      kbd_data   <= '0;
      err_pulse  <= 1'b0;
    end else begin
      pstate_q  <= pstate_d;
      a20_gate  <= gate_d;
      kbd_valid <= kbd_hit;
      err_pulse <= bad_hit;
      if (kbd_hit) kbd_data <= wr_byte;
      if (ev_cmd && kind == CK_RAM_WR) ram_addr_q <= cmd_addr;
    end
  end

  kbc_ctl_ram #(.DEPTH(RAM_DEPTH), .DW(8), .DEFAULT0(RAM0_INIT)) u_ram (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .waddr (ram_addr_q),
    .wdata (wr_byte),
    .raddr (cmd_addr),
    .rdata (ram_rdata)
  );

  kbc_rsp_hold #(.DW(8)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rsp_load),
    .load_byte (rsp_byte),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  AST_GATE_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> a20_gate == $past(a20_gate)) else $error("gate moved idle"); // R4
  AST_PULSE_SETS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && wr_byte[7:4] == 4'hF) |=> a20_gate == $past(wr_byte[1]))
    else $error("pulse gate"); // R5
  AST_KBD_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid |-> $past(ev_data)) else $error("kbd strobe w/o data"); // R8
  AST_ERR_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> ($past(ev_cmd) && a20_gate == $past(a20_gate)))
    else $error("err w/o cmd"); // R10
  AST_OUTPORT_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cmd && wr_byte == OP_RD_OUTPORT) |=> (rsp_valid && rsp_data[0]))
    else $error("outport bit0"); // R2
endmodule

// File: tb/sim_kbc_cmd_decoder.sv
module sim_kbc_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, wr_is_cmd = 1'b0;
  logic [7:0] wr_byte = '0;
  logic pend = 1'b0, chr = 1'b0, rsp_ready = 1'b1;
  logic rsp_valid, kbd_valid, a20_gate, err_pulse;
  logic [7:0] rsp_data, kbd_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_is_cmd(wr_is_cmd),
    .wr_byte(wr_byte), .host_in_pending(pend), .out_char_waiting(chr),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data), .a20_gate(a20_gate),
    .err_pulse(err_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // one-cycle write; returns at the falling edge after the taking edge
  task automatic put(input bit is_cmd, input logic [7:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_is_cmd = is_cmd; wr_byte = b;
    @(negedge clk);
    wr_valid = 1'b0; wr_is_cmd = 1'b0; wr_byte = '0;
  endtask

  function automatic logic [7:0] exp_status(bit p, bit c, bit g);
    logic [7:0] v;
    v = 8'h01;
    if (p) v = v | 8'h20;
    if (c) v = v | 8'h10;
    if (g) v = v | 8'h02;
    return v;
  endfunction

  task automatic t_reset;
    chk("R1 gate", a20_gate, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 kbd_valid", kbd_valid, 0);
    chk("R1 err", err_pulse, 0);
    put(1, 8'h20);
    chk("R1 ram0 valid", rsp_valid, 1);
    chk("R1 ram0", rsp_data, 8'h45);
    put(1, 8'h25);
    chk("R1 ram5", rsp_data, 8'h00);
  endtask

  task automatic t_selftest;
    put(1, 8'hAA);
    chk("R6 valid", rsp_valid, 1);
    chk("R6 byte", rsp_data, 8'h55);
  endtask

  task automatic t_gate_cmds;
    put(1, 8'hDF);
    chk("R4 on", a20_gate, 1);
    chk("R4 no rsp", rsp_valid, 0);
    repeat (3) @(negedge clk);
    chk("R4 idle stable", a20_gate, 1);
    put(1, 8'hDD);
    chk("R4 off", a20_gate, 0);
  endtask

  task automatic t_read_outport;
    for (int k = 0; k < 8; k++) begin
      put(1, k[2] ? 8'hDF : 8'hDD);
      pend = k[0]; chr = k[1];
      put(1, 8'hD0);
      chk("R2 valid", rsp_valid, 1);
      chk("R2 status", rsp_data, exp_status(k[0], k[1], k[2]));
    end
    pend = 0; chr = 0;
  endtask

  task automatic t_write_outport;
    put(1, 8'hDD);
    put(1, 8'hD1);
    chk("R3 no rsp", rsp_valid, 0);
    chk("R3 gate held", a20_gate, 0);
    put(0, 8'h02);
    chk("R3 gate set", a20_gate, 1);
    chk("R3 no kbd", kbd_valid, 0);
    put(1, 8'hD1);
    put(0, 8'hFD);
    chk("R3 gate clr", a20_gate, 0);
    put(0, 8'h02);
    chk("R3 back normal kbd", kbd_valid, 1);
    chk("R3 back normal gate", a20_gate, 0);
  endtask

  task automatic t_pulse;
    for (int c = 8'hF0; c <= 8'hFF; c++) begin
      put(1, 8'(c));
      chk("R5 pulse gate", a20_gate, (c >> 1) & 1);
      chk("R5 no err", err_pulse, 0);
    end
  endtask

  task automatic t_ram;
    put(1, 8'h60); put(0, 8'hA5);
    chk("R7 no kbd", kbd_valid, 0);
    put(1, 8'h7F); put(0, 8'h3C);
    put(1, 8'h6A); put(0, 8'h0F);
    put(1, 8'h20); chk("R7 rd0", rsp_data, 8'hA5);
    put(1, 8'h3F); chk("R7 rd31", rsp_data, 8'h3C);
    put(1, 8'h2A); chk("R7 rd10", rsp_data, 8'h0F);
    put(1, 8'h21); chk("R7 rd1 untouched", rsp_data, 8'h00);
  endtask

  task automatic t_kbd;
    put(1, 8'hDF);
    put(0, 8'h00);
    chk("R8 strobe", kbd_valid, 1);
    chk("R8 data", kbd_data, 8'h00);
    chk("R8 gate kept", a20_gate, 1);
    @(negedge clk);
    chk("R8 one cycle", kbd_valid, 0);
    put(0, 8'h9E);
    chk("R8 data2", kbd_data, 8'h9E);
  endtask

  task automatic t_cancel;
    put(1, 8'hD1);
    put(1, 8'hDF);
    put(0, 8'h00);
    chk("R9 gate kept", a20_gate, 1);
    chk("R9 kbd strobe", kbd_valid, 1);
    chk("R9 kbd data", kbd_data, 8'h00);
    put(1, 8'h65);
    put(1, 8'hAA);
    put(0, 8'h77);
    chk("R9 ram path kbd", kbd_valid, 1);
    put(1, 8'h25);
    chk("R9 ram5 kept", rsp_data, 8'h00);
  endtask

  task automatic t_bad;
    put(1, 8'hDD);
    put(1, 8'h13);
    chk("R10 err", err_pulse, 1);
    chk("R10 no rsp", rsp_valid, 0);
    chk("R10 gate", a20_gate, 0);
    @(negedge clk);
    chk("R10 err one cycle", err_pulse, 0);
    put(1, 8'hDF);
    put(1, 8'hD2);
    chk("R10 err2", err_pulse, 1);
    chk("R10 gate2", a20_gate, 1);
  endtask

  task automatic t_hold;
    rsp_ready = 0;
    put(1, 8'hAA);
    repeat (4) @(negedge clk);
    chk("R11 held valid", rsp_valid, 1);
    chk("R11 held data", rsp_data, 8'h55);
    rsp_ready = 1;
    @(negedge clk);
    chk("R11 cleared", rsp_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_selftest();
    t_gate_cmds();
    t_read_outport();
    t_write_outport();
    t_pulse();
    t_ram();
    t_kbd();
    t_cancel();
    t_bad();
    t_hold();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule